// File: doc/BRIEF.md
# RTC Tick Counter and Interrupt Flag Registers

This block is the register front end of a real-time clock. It keeps a free-running 15-bit sub-second tick counter that advances on strobes from an external prescaler. It also holds a two-bit interrupt flag register with write-one-to-clear semantics, an 8-bit per-field increment interrupt enable, an 8-bit alarm field mask and a 4-bit clock control register. The time-of-day counters and the alarm comparators sit outside. Each of the eight time fields reports an increment strobe and an alarm-match bit, with bit 0 as seconds.

Software reaches the registers over a simple word-addressed bus. `busAddr` is the word index, which is the byte offset divided by four. Reads are combinational from the current register state. To acknowledge interrupts, software reads the flag register and writes the same value back. This clears only the flags it observed. A flag raised by hardware in the same cycle as the clear survives. A single registered interrupt output stays high while either flag is set.

Top module: `rtc_irq_regs`

## Requirements
- R1: After reset every register reads 0 and `irqOut` is 0.
- R2: Word 0 is the flag register. Bit 0 is the increment flag, bit 1 is the alarm flag, and bits 31:2 read 0. Writing 1 to a flag bit clears that flag on the next edge. Writing 0 to a flag bit leaves that flag unchanged.
- R3: When a hardware set and a software clear of the same flag fall in one cycle, the flag is set after the edge.
- R4: The increment flag sets on the edge where `fieldInc[i]` and enable bit i (word 3) are both 1, for any i. An increment strobe whose enable bit is 0 does not set it.
- R5: The alarm flag sets on the edge where `fieldInc[0]` (the seconds increment) is 1 and, for every field i, `fieldMatch[i]` is 1 or mask bit i (word 4) is 1.
- R6: Word 1 returns the tick counter in bits 15:1, with bit 0 and bits 31:16 reading 0. The counter advances by one on each edge where `tickStrobe` is 1 and control bit 0 (run) is 1. It wraps from 32767 to 0. Writes to word 1 are ignored.
- R7: While control bit 1 (tick clear) is 1, the tick counter is 0 after each edge.
- R8: Word 2 is the 4-bit control register, word 3 the 8-bit increment enable and word 4 the 8-bit alarm mask. Each reads back what was written, and bits above its width read 0. Words 5 to 7 read 0, and `busRdata` is 0 while `busSel` is 0.
- R9: `irqOut` equals the OR of the two flags as they stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | Access is a write |
| busAddr | input | 3 | Word index of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational) |
| tickStrobe | input | 1 | One tick from the prescaler |
| fieldInc | input | 8 | Per-field increment strobes, bit 0 = seconds |
| fieldMatch | input | 8 | Per-field alarm match bits |
| irqOut | output | 1 | Registered interrupt request |

## Verification
Read data is due in the same cycle as the address, so the bench drives the inputs just after the falling edge and samples one nanosecond later. Flags, counter and stored registers change at the next rising edge. `irqOut` follows the flags one edge later still, making it due two edges after the event that caused it. The behavioural model in the bench applies each cycle's inputs at the rising edge in the same order as the hardware. Every comparison against that model is therefore made against the state due at that sample point, with no extra delay allowance.

// File: rtl/rtc_regs_pkg.sv
package rtc_regs_pkg;

  localparam int WORD_FLAGS = 0;
  localparam int WORD_TICK  = 1;
  localparam int WORD_CTRL  = 2;
  localparam int WORD_INCEN = 3;
  localparam int WORD_MASK  = 4;

  typedef enum logic [2:0] {
    SEL_FLAGS,
    SEL_TICK,
    SEL_CTRL,
    SEL_INCEN,
    SEL_MASK,
    SEL_NONE
  } readSel_t;

  typedef struct packed {
    logic wrFlags;
    logic wrCtrl;
    logic wrIncEn;
    logic wrMask;
  } regStrobes_t;

endpackage

// File: rtl/rtc_regs_ctrl.sv
module rtc_regs_ctrl
  import rtc_regs_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobes_t       strobes,
  output readSel_t          rdSel
);

  logic doWrite;
  assign doWrite = busSel && busWrite;

  always_comb begin
    strobes = '0;
    if (doWrite) begin
      strobes.wrFlags = (int'(busAddr) == WORD_FLAGS);
      strobes.wrCtrl  = (int'(busAddr) == WORD_CTRL);
      strobes.wrIncEn = (int'(busAddr) == WORD_INCEN);
      strobes.wrMask  = (int'(busAddr) == WORD_MASK);
    end
  end

  always_comb begin
    rdSel = SEL_NONE;
    if (busSel) begin
      case (int'(busAddr))
        WORD_FLAGS: rdSel = SEL_FLAGS;
        WORD_TICK:  rdSel = SEL_TICK;
        WORD_CTRL:  rdSel = SEL_CTRL;
        WORD_INCEN: rdSel = SEL_INCEN;
        WORD_MASK:  rdSel = SEL_MASK;
        default:    rdSel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/rtc_regs_dp.sv
module rtc_regs_dp
  import rtc_regs_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TICK_W  = 15,
  parameter int CTRL_W  = 4,
  parameter int FIELD_N = 8,
  parameter int FLAG_N  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  regStrobes_t        strobes,
  input  readSel_t           rdSel,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic               tickStrobe,
  input  logic [FIELD_N-1:0] fieldInc,
  input  logic [FIELD_N-1:0] fieldMatch,
  output logic [DATA_W-1:0]  busRdata,
  output logic [FLAG_N-1:0]  flagQ,
  output logic [TICK_W-1:0]  tickQ,
  output logic [CTRL_W-1:0]  ctrlQ,
  output logic [FIELD_N-1:0] incEnQ,
  output logic [FIELD_N-1:0] maskQ,
  output logic               irqQ
);

  localparam int CTRL_RUN   = 0;
  localparam int CTRL_CLEAR = 1;
  localparam int FLAG_INC   = 0;
  localparam int FLAG_ALARM = 1;

  // Hardware set requests per flag
  logic [FLAG_N-1:0] flagSet;
  logic [FLAG_N-1:0] flagClr;

  always_comb begin
    flagSet = '0;
    flagSet[FLAG_INC]   = |(fieldInc & incEnQ);
    flagSet[FLAG_ALARM] = fieldInc[0] && (&(fieldMatch | maskQ));
  end

  assign flagClr = strobes.wrFlags ? busWdata[FLAG_N-1:0] : '0;

  genvar gi;
  generate
    for (gi = 0; gi < FLAG_N; gi++) begin : g_flag
      always_ff @(posedge clk) begin
        if (!rstN)              flagQ[gi] <= 1'b0;
        else if (flagSet[gi])   flagQ[gi] <= 1'b1;  // set has priority
        else if (flagClr[gi])   flagQ[gi] <= 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)
      irqQ <= 1'b0;
    else
      irqQ <= |flagQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      tickQ <= '0;
    else if (ctrlQ[CTRL_CLEAR])
      tickQ <= '0;
    else if (ctrlQ[CTRL_RUN] && tickStrobe)
      tickQ <= tickQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ  <= '0;
      incEnQ <= '0;
      maskQ  <= '0;
    end else begin
      if (strobes.wrCtrl)  ctrlQ  <= busWdata[CTRL_W-1:0];
      if (strobes.wrIncEn) incEnQ <= busWdata[FIELD_N-1:0];
      if (strobes.wrMask)  maskQ  <= busWdata[FIELD_N-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    case (rdSel)
      SEL_FLAGS: busRdata[FLAG_N-1:0]  = flagQ;
      SEL_TICK:  busRdata[TICK_W:1]    = tickQ;
      SEL_CTRL:  busRdata[CTRL_W-1:0]  = ctrlQ;
      SEL_INCEN: busRdata[FIELD_N-1:0] = incEnQ;
      SEL_MASK:  busRdata[FIELD_N-1:0] = maskQ;
      default:   busRdata = '0;
    endcase
  end

endmodule

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs
  import rtc_regs_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32,
  parameter int TICK_W  = 15,
  parameter int CTRL_W  = 4,
  parameter int FIELD_N = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  input  logic               tickStrobe,
  input  logic [FIELD_N-1:0] fieldInc,
  input  logic [FIELD_N-1:0] fieldMatch,
  output logic               irqOut
);

  localparam int FLAG_N = 2;

  regStrobes_t        strobes;
  readSel_t           rdSel;
  logic [FLAG_N-1:0]  flagQ;
  logic [TICK_W-1:0]  tickQ;
  logic [CTRL_W-1:0]  ctrlQ;
  logic [FIELD_N-1:0] incEnQ;
  logic [FIELD_N-1:0] maskQ;

  rtc_regs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobes  (strobes),
    .rdSel    (rdSel)
  );

  rtc_regs_dp #(
    .DATA_W  (DATA_W),
    .TICK_W  (TICK_W),
    .CTRL_W  (CTRL_W),
    .FIELD_N (FIELD_N),
    .FLAG_N  (FLAG_N)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .rdSel      (rdSel),
    .busWdata   (busWdata),
    .tickStrobe (tickStrobe),
    .fieldInc   (fieldInc),
    .fieldMatch (fieldMatch),
    .busRdata   (busRdata),
    .flagQ      (flagQ),
    .tickQ      (tickQ),
    .ctrlQ      (ctrlQ),
    .incEnQ     (incEnQ),
    .maskQ      (maskQ),
    .irqQ       (irqOut)
  );

endmodule

// File: rtl/rtc_regs_chk.sv
module rtc_regs_chk #(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 32,
  parameter int TICK_W  = 15,
  parameter int CTRL_W  = 4,
  parameter int FIELD_N = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               busSel,
  input logic               busWrite,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [DATA_W-1:0]  busWdata,
  input logic               tickStrobe,
  input logic [FIELD_N-1:0] fieldInc,
  input logic [FIELD_N-1:0] fieldMatch,
  input logic [1:0]         flagQ,
  input logic [TICK_W-1:0]  tickQ,
  input logic [CTRL_W-1:0]  ctrlQ,
  input logic [FIELD_N-1:0] incEnQ,
  input logic [FIELD_N-1:0] maskQ,
  input logic               irqOut
);

  logic wrFlagWord;
  logic incEvent;
  logic alarmEvent;

  assign wrFlagWord = busSel && busWrite && (busAddr == '0);
  assign incEvent   = |(fieldInc & incEnQ);
  assign alarmEvent = fieldInc[0] && ((fieldMatch | maskQ) == '1);

  assert_irq_registered_R9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irqOut == $past(|flagQ));

  assert_inc_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
    incEvent |=> flagQ[0]);

  assert_alarm_sets_R5: assert property (@(posedge clk) disable iff (!rstN)
    alarmEvent |=> flagQ[1]);

  assert_set_beats_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrFlagWord && busWdata[1] && alarmEvent) |=> flagQ[1]);

  assert_one_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrFlagWord && busWdata[0] && !incEvent) |=> !flagQ[0]);

  assert_zero_keeps_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrFlagWord && !busWdata[1] && flagQ[1]) |=> flagQ[1]);

  assert_tick_cleared_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[1] |=> tickQ == '0);

  assert_tick_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlQ[1] && !(ctrlQ[0] && tickStrobe)) |=> $stable(tickQ));

endmodule

bind rtc_irq_regs rtc_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TICK_W(TICK_W),
  .CTRL_W(CTRL_W), .FIELD_N(FIELD_N)
) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busWdata(busWdata), .tickStrobe(tickStrobe),
  .fieldInc(fieldInc), .fieldMatch(fieldMatch), .flagQ(flagQ),
  .tickQ(tickQ), .ctrlQ(ctrlQ), .incEnQ(incEnQ), .maskQ(maskQ),
  .irqOut(irqOut)
);

// File: tb/tb_rtc_irq_regs.sv
`timescale 1ns/1ps
module tb_rtc_irq_regs;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        tickStrobe = 1'b0;
  logic [7:0]  fieldInc = '0;
  logic [7:0]  fieldMatch = '0;
  logic        irqOut;

  always #10 clk = ~clk;  // 50 MHz

  rtc_irq_regs dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .tickStrobe(tickStrobe), .fieldInc(fieldInc), .fieldMatch(fieldMatch),
    .irqOut(irqOut)
  );

  // Behavioural reference state
  int mFlags, mTick, mCtrl, mIncEn, mMask, mIrq;
  int vectors = 0;
  int misses = 0;
  string phase = "";
  bit finished = 0;

  function automatic int modelRead(input bit sel, input int addr);
    if (!sel) return 0;
    case (addr)
      0: return mFlags;
      1: return mTick * 2;
      2: return mCtrl;
      3: return mIncEn;
      4: return mMask;
      default: return 0;
    endcase
  endfunction

  function automatic string regTag(input int addr);
    case (addr)
      0: return "R2";
      1: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic compareNow();
    int expRd;
    expRd = modelRead(busSel, int'(busAddr));
    vectors++;
    if (busRdata !== 32'(expRd)) begin
      misses++;
      $display("FAIL %s/%s rdata word %0d actual %h expected %h",
               phase, regTag(int'(busAddr)), busAddr, busRdata, 32'(expRd));
    end
    vectors++;
    if (irqOut !== mIrq[0]) begin
      misses++;
      $display("FAIL %s/R9 irqOut actual %0b expected %0b", phase, irqOut, mIrq[0]);
    end
  endtask

  task automatic modelStep();
    int clr, incEv, alEv, nFlags;
    clr   = (busSel && busWrite && busAddr == 0) ? int'(busWdata[1:0]) : 0;
    incEv = ((int'(fieldInc) & mIncEn) != 0) ? 1 : 0;
    alEv  = (fieldInc[0] && ((int'(fieldMatch) | mMask) == 255)) ? 2 : 0;
    nFlags = (mFlags & ~clr) | incEv | alEv;
    mIrq = (mFlags != 0) ? 1 : 0;
    if ((mCtrl & 2) != 0) mTick = 0;
    else if ((mCtrl & 1) != 0 && tickStrobe) mTick = (mTick + 1) % 32768;
    if (busSel && busWrite) begin
      case (int'(busAddr))
        2: mCtrl  = int'(busWdata[3:0]);
        3: mIncEn = int'(busWdata[7:0]);
        4: mMask  = int'(busWdata[7:0]);
        default: ;
      endcase
    end
    mFlags = nFlags;
  endtask

  task automatic cyc(input bit sel, input bit wr, input int addr, input int wd,
                     input bit tk, input int inc, input int match);
    @(negedge clk);
    busSel = sel; busWrite = wr; busAddr = 3'(addr); busWdata = 32'(wd);
    tickStrobe = tk; fieldInc = 8'(inc); fieldMatch = 8'(match);
    #1;
    compareNow();
    @(posedge clk);
    modelStep();
  endtask

  task automatic rd(input int addr);
    cyc(1, 0, addr, 0, 0, 0, 0);
  endtask

  task automatic wr(input int addr, input int wd);
    cyc(1, 1, addr, wd, 0, 0, 0);
  endtask

  initial begin
    mFlags = 0; mTick = 0; mCtrl = 0; mIncEn = 0; mMask = 0; mIrq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    phase = "R1 reset";
    for (int a = 0; a < 8; a++) rd(a);

    phase = "R8 readback";
    wr(2, 32'hFFFF_FFFF); rd(2);
    wr(3, 32'hFFFF_FF5A); rd(3);
    wr(4, 32'hABCD_EF3C); rd(4);
    for (int a = 5; a < 8; a++) rd(a);
    cyc(0, 0, 2, 0, 0, 0, 0);

    phase = "R7 clear";
    wr(2, 3);
    for (int i = 0; i < 20; i++) cyc(1, 0, 1, 0, 1, 0, 0);

    phase = "R6 count";
    wr(2, 1);
    for (int i = 0; i < 33000; i++) cyc(1, 0, 1, 0, (i % 5) != 3, 0, 0);
    wr(1, 32'hFFFF_FFFF); rd(1);
    wr(2, 0);
    for (int i = 0; i < 10; i++) cyc(1, 0, 1, 0, 1, 0, 0);

    phase = "R4 increment";
    wr(4, 0); wr(3, 32'h0A);
    cyc(1, 0, 0, 0, 0, 8'h05, 0); rd(0); rd(0);
    cyc(1, 0, 0, 0, 0, 8'h08, 0); rd(0); rd(0);

    phase = "R2 clear";
    wr(0, 2); rd(0);
    wr(0, 1); rd(0); rd(0);

    phase = "R5 alarm";
    wr(4, 32'hF0);
    cyc(1, 0, 0, 0, 0, 8'h01, 8'h0E); rd(0);
    cyc(1, 0, 0, 0, 0, 8'h02, 8'h0F); rd(0);
    cyc(1, 0, 0, 0, 0, 8'h01, 8'h0F); rd(0); rd(0);
    wr(0, 0); rd(0);

    phase = "R3 set wins";
    cyc(1, 1, 0, 3, 0, 8'h03, 8'hFF); rd(0);
    cyc(1, 1, 0, 3, 0, 0, 0); rd(0); rd(0);

    phase = "random";
    for (int i = 0; i < 4000; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      cyc(($urandom_range(0, 7) != 0), (op < 4), int'($urandom_range(0, 7)),
          (op == 0) ? int'($urandom_range(0, 3)) : int'($urandom),
          $urandom_range(0, 1) == 1,
          ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 255)) : 0,
          ($urandom_range(0, 1) == 1) ? 255 : int'($urandom_range(0, 255)));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog expired in phase %s", phase);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

endmodule